// File: doc/BRIEF.md
# STOP-Mode Wake-Up Source Controller

This block decides when a device sleeping in STOP wakes up. Software programs two configuration registers. The primary register picks a wake source: one port pin, or a NOR over a group of port-2 bits. It also holds the active wake level, a post-wake delay enable and two system-clock divider controls. The secondary register offers an AND over a group of port-2 bits. The secondary source applies only when the primary source is set to "no pin source".

A one-cycle strobe puts the block into STOP. While STOP is active, the selected source is compared every clock against the programmed level. A match ends STOP and pulses a wake request. The same match can start a fixed-length delay window, during which the processor should hold off execution. A read-only flag in bit 7 of the primary register reports how the device last started. It reads 0 after a power-on reset and 1 once any recovery from STOP has happened.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `stop_active`, `wake_req`, `delay_active`, `clk_div16` and `clk_undiv` are all 0 and `rd_data` reads 8'h00.
- R2: A `stop_enter` pulse sampled at a clock edge makes `stop_active` 1 after that edge. While `stop_active` is 0, no pin pattern produces a `wake_req`.
- R3: Primary source field `wr_data[4:2]`, written with `wr_sel`=0, selects a single pin: 001 `p3_pins[0]`, 010 `p3_pins[1]`, 011 `p3_pins[2]`, 100 `p3_pins[3]`, 101 `p2_pins[7]`. A wake occurs when the pin equals the level bit `wr_data[6]` (0 = low, 1 = high).
- R4: Primary source 110 uses the NOR of `p2_pins[3:0]` and 111 uses the NOR of `p2_pins[7:0]`. Each is compared with the level bit in the same way.
- R5: Secondary source field `wr_data[1:0]`, written with `wr_sel`=1, applies only when the primary source is 000: 01 uses the AND of `p2_pins[3:0]` and 10 the AND of `p2_pins[7:0]`, compared with the level bit.
- R6: With primary source 000 and secondary source 00 or 11, no pin pattern wakes the block.
- R7: A match sampled at an edge while `stop_active` is 1 makes `stop_active` 0 and `wake_req` 1 after that edge. `wake_req` stays high for exactly one cycle.
- R8: `rd_data[7]` is the recovery flag: 0 after `rst`, 1 after the first wake, unaffected by writes or later STOP entries until the next `rst`. `rd_data[6:0]` always reads 0.
- R9: If delay-enable bit `wr_data[5]` (reset value 1) is set when the wake occurs, `delay_active` is 1 for exactly `DELAY_CYCLES` cycles, starting in the cycle `wake_req` is high. If the bit is clear, `delay_active` stays 0.
- R10: One cycle after a primary write, `clk_div16` follows `wr_data[0]` and `clk_undiv` follows `wr_data[1]`. A wake clears `clk_div16` and leaves `clk_undiv` unchanged.
- R11: When the primary source is nonzero, the secondary source has no effect on waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| p3_pins | input | 4 | Port-3 single-pin wake candidates |
| p2_pins | input | 8 | Port-2 pins for single, NOR and AND sources |
| stop_enter | input | 1 | One-cycle request to enter STOP |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = primary register, 1 = secondary register |
| wr_data | input | 7 | Write data (bit 7 of the primary register has no write path) |
| rd_data | output | 8 | Primary register read value: recovery flag in bit 7 |
| stop_active | output | 1 | Block is in STOP and watching for a wake event |
| wake_req | output | 1 | One-cycle wake pulse |
| delay_active | output | 1 | Post-wake delay window in progress |
| clk_div16 | output | 1 | Apply divide-by-16 to the system clock |
| clk_undiv | output | 1 | 1 = system clock is the undivided crystal, 0 = crystal/2 |

## Verification
The assertions assume that `rst` is high for at least one edge before any checked behaviour. They also assume that `stop_enter` is the only way into STOP, which makes every rising edge of `stop_active` traceable to a sampled strobe. The bench resets the block before each swept case, so every configuration starts from a known state. It holds pins steady from the STOP entry through the sampling edge, so the wake decision depends on one pattern only. The sweep covers every primary and secondary source, both levels, and pin patterns chosen to make each NOR and AND group both true and false.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int P3_PINS  = 4;
    localparam int P2_PINS  = 8;
    localparam int P2_LOW   = 4;
    localparam int CFG_W    = 7;
    localparam int SEC_W    = 2;

    typedef enum logic [2:0] {
        PSRC_NONE    = 3'd0,
        PSRC_P3_0    = 3'd1,
        PSRC_P3_1    = 3'd2,
        PSRC_P3_2    = 3'd3,
        PSRC_P3_3    = 3'd4,
        PSRC_P2_7    = 3'd5,
        PSRC_NOR_LO  = 3'd6,
        PSRC_NOR_ALL = 3'd7
    } psrc_e;

    typedef enum logic [SEC_W-1:0] {
        SSRC_NONE    = 2'd0,
        SSRC_AND_LO  = 2'd1,
        SSRC_AND_ALL = 2'd2,
        SSRC_RSVD    = 2'd3
    } ssrc_e;

    // Field order follows the write-data bit positions (bit 6 down to bit 0).
    typedef struct packed {
        logic  level;
        logic  dly_en;
        psrc_e src;
        logic  clk_undiv;
        logic  div16;
    } prim_cfg_t;

    localparam prim_cfg_t PRIM_RESET = '{
        level:     1'b0,
        dly_en:    1'b1,
        src:       PSRC_NONE,
        clk_undiv: 1'b0,
        div16:     1'b0
    };

    function automatic logic grp_nor(input logic [P2_PINS-1:0] v, input logic wide);
        return wide ? ~(|v) : ~(|v[P2_LOW-1:0]);
    endfunction

    function automatic logic grp_and(input logic [P2_PINS-1:0] v, input logic wide);
        return wide ? (&v) : (&v[P2_LOW-1:0]);
    endfunction

endpackage

// File: rtl/smr_cfg_regs.sv
module smr_cfg_regs
    import smr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             wake_evt,
    output prim_cfg_t        prim,
    output ssrc_e            sec
);
    logic sec_unused;
    assign sec_unused = ^wr_data[CFG_W-1:SEC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            prim <= PRIM_RESET;
            sec  <= SSRC_NONE;
        end else begin
            if (wr_en && !wr_sel)
                prim <= prim_cfg_t'(wr_data);
            if (wr_en && wr_sel)
                sec <= ssrc_e'(wr_data[SEC_W-1:0]);
            // Recovery forces the fast clock back on, overriding a same-cycle write.
            if (wake_evt)
                prim.div16 <= 1'b0;
        end
    end
endmodule

// File: rtl/smr_src_match.sv
module smr_src_match
    import smr_pkg::*;
(
    input  prim_cfg_t          prim,
    input  ssrc_e              sec,
    input  logic [P3_PINS-1:0] p3_pins,
    input  logic [P2_PINS-1:0] p2_pins,
    output logic               match
);
    logic sel_val;
    logic sel_ok;

    always_comb begin
        sel_val = 1'b0;
        sel_ok  = 1'b1;
        unique case (prim.src)
            PSRC_P3_0:    sel_val = p3_pins[0];
            PSRC_P3_1:    sel_val = p3_pins[1];
            PSRC_P3_2:    sel_val = p3_pins[2];
            PSRC_P3_3:    sel_val = p3_pins[3];
            PSRC_P2_7:    sel_val = p2_pins[P2_PINS-1];
            PSRC_NOR_LO:  sel_val = grp_nor(p2_pins, 1'b0);
            PSRC_NOR_ALL: sel_val = grp_nor(p2_pins, 1'b1);
            PSRC_NONE: begin
                unique case (sec)
                    SSRC_AND_LO:  sel_val = grp_and(p2_pins, 1'b0);
                    SSRC_AND_ALL: sel_val = grp_and(p2_pins, 1'b1);
                    default:      sel_ok  = 1'b0;
                endcase
            end
            default: sel_ok = 1'b0;
        endcase
    end

    assign match = sel_ok && (sel_val == prim.level);
endmodule

// File: rtl/smr_delay_timer.sv
module smr_delay_timer #(
    parameter int DELAY_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYCLES);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import smr_pkg::*;
#(
    parameter int DELAY_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [P3_PINS-1:0] p3_pins,
    input  logic [P2_PINS-1:0] p2_pins,
    input  logic               stop_enter,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CFG_W:0]     rd_data,
    output logic               stop_active,
    output logic               wake_req,
    output logic               delay_active,
    output logic               clk_div16,
    output logic               clk_undiv
);
    prim_cfg_t prim;
    ssrc_e     sec;
    logic      match;
    logic      wake_evt;
    logic      rec_flag;

    assign wake_evt = stop_active && match;

    smr_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .wake_evt (wake_evt),
        .prim     (prim),
        .sec      (sec)
    );

    smr_src_match u_match (
        .prim    (prim),
        .sec     (sec),
        .p3_pins (p3_pins),
        .p2_pins (p2_pins),
        .match   (match)
    );

    smr_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .start (wake_evt && prim.dly_en),
        .busy  (delay_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_active <= 1'b0;
            wake_req    <= 1'b0;
            rec_flag    <= 1'b0;
        end else begin
            wake_req <= wake_evt;
            if (wake_evt) begin
                stop_active <= 1'b0;
                rec_flag    <= 1'b1;
            end else if (stop_enter) begin
                stop_active <= 1'b1;
            end
        end
    end

    assign rd_data   = {rec_flag, {CFG_W{1'b0}}};
    assign clk_div16 = prim.div16;
    assign clk_undiv = prim.clk_undiv;
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
    parameter int DELAY_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst,
    input logic       stop_enter,
    input logic [7:0] rd_data,
    input logic       stop_active,
    input logic       wake_req,
    input logic       delay_active,
    input logic       clk_div16
);
    localparam int RUN_W = $clog2(DELAY_CYCLES + 2);
    logic [RUN_W-1:0] dly_run;

    always_ff @(posedge clk) begin
        if (rst)
            dly_run <= '0;
        else if (delay_active)
            dly_run <= dly_run + 1'b1;
        else
            dly_run <= '0;
    end

    assert_enter_only_by_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_active) |-> $past(stop_enter));

    assert_wake_ends_stop_R7: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ($past(stop_active) && !stop_active));

    assert_wake_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

    assert_flag_set_on_wake_R8: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> rd_data[7]);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[7]) |-> $past(rst));

    assert_low_bits_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:0] == 7'd0);

    assert_delay_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        dly_run <= RUN_W'(DELAY_CYCLES));

    assert_wake_fast_clock_R10: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> !clk_div16);
endmodule

bind stop_wake_ctrl smr_checker #(.DELAY_CYCLES(DELAY_CYCLES)) u_smr_chk (
    .clk          (clk),
    .rst          (rst),
    .stop_enter   (stop_enter),
    .rd_data      (rd_data),
    .stop_active  (stop_active),
    .wake_req     (wake_req),
    .delay_active (delay_active),
    .clk_div16    (clk_div16)
);

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] p3_pins = 4'hF;
    logic [7:0] p2_pins = 8'hFF;
    logic       stop_enter = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [6:0] wr_data = 7'd0;
    logic [7:0] rd_data;
    logic       stop_active, wake_req, delay_active, clk_div16, clk_undiv;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_wake_ctrl #(.DELAY_CYCLES(DLY)) i_stop_wake_ctrl (
        .clk(clk), .rst(rst), .p3_pins(p3_pins), .p2_pins(p2_pins),
        .stop_enter(stop_enter), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .stop_active(stop_active), .wake_req(wake_req),
        .delay_active(delay_active), .clk_div16(clk_div16), .clk_undiv(clk_undiv)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; stop_enter = 1'b0; wr_en = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [6:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic exp_wake(input int p, input int s, input logic lvl,
                                      input logic [3:0] a, input logic [7:0] b);
        logic v;
        case (p)
            1, 2, 3, 4: v = a[p-1];
            5: v = b[7];
            6: v = (b[3:0] == 4'h0);
            7: v = (b == 8'h00);
            default: begin
                if (s == 1)      v = (b[3:0] == 4'hF);
                else if (s == 2) v = (b == 8'hFF);
                else return 1'b0;
            end
        endcase
        return v == lvl;
    endfunction

    logic [3:0] p3v [4] = '{4'h0, 4'hF, 4'h5, 4'hA};
    logic [7:0] p2v [8] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h01, 8'h80, 8'hFE, 8'h7F};

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        string rq;
        logic e;
        // R1: reset state
        tick();
        chk("R1 stop_active", stop_active, 0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 delay_active", delay_active, 0);
        chk("R1 clk bits", {clk_div16, clk_undiv}, 2'b00);
        rst = 1'b0;
        tick();
        chk("R1 after release", {stop_active, wake_req, delay_active, clk_div16, clk_undiv}, 0);

        // R2: matching pins without STOP give no wake
        wr(1'b0, 7'b0_0_001_00);
        p3_pins = 4'h0;
        tick(); tick();
        chk("R2 no wake outside stop", wake_req, 0);
        chk("R2 flag unchanged", rd_data, 8'h00);

        // Sweep: R3 R4 R5 R6 R11
        for (int p = 0; p < 8; p++)
          for (int s = 0; s < 4; s++)
            for (int l = 0; l < 2; l++)
              for (int i = 0; i < 4; i++)
                for (int j = 0; j < 8; j++) begin
                    if (p >= 1 && p <= 5) rq = "R3";
                    else if (p >= 6) rq = "R4";
                    else if (s == 1 || s == 2) rq = "R5";
                    else rq = "R6";
                    if (p != 0 && s != 0 && j == 0) rq = {rq, "/R11"};
                    do_reset();
                    wr(1'b0, {l[0], 1'b0, p[2:0], 2'b00});
                    wr(1'b1, {5'd0, s[1:0]});
                    p3_pins = p3v[i]; p2_pins = p2v[j];
                    e = exp_wake(p, s, l[0], p3v[i], p2v[j]);
                    stop_enter = 1'b1;
                    tick();
                    stop_enter = 1'b0;
                    chk("R2 stop entered", {stop_active, wake_req}, 2'b10);
                    tick();
                    chk({rq, " R7 wake_req"}, wake_req, e);
                    chk({rq, " R7 stop_active"}, stop_active, !e);
                    chk({rq, " R8 flag"}, rd_data, e ? 8'h80 : 8'h00);
                end

        // R9 delay window and R10 clock controls
        do_reset();
        wr(1'b0, 7'b0_1_001_11);
        chk("R10 div16 set", clk_div16, 1);
        chk("R10 undiv set", clk_undiv, 1);
        p3_pins = 4'hF;
        stop_enter = 1'b1; tick(); stop_enter = 1'b0;
        tick();
        chk("R2 no wake while pin high", stop_active, 1);
        p3_pins = 4'hE;
        tick();
        chk("R7 wake", wake_req, 1);
        chk("R9 delay starts with wake", delay_active, 1);
        chk("R10 div16 cleared by wake", clk_div16, 0);
        chk("R10 undiv kept", clk_undiv, 1);
        cnt = 0;
        while (delay_active && cnt < 4000) begin
            cnt++;
            tick();
            if (cnt == 1) chk("R7 single pulse", wake_req, 0);
        end
        chk("R9 delay length", cnt, DLY);

        // R8 flag sticky across writes and a later STOP
        wr(1'b0, 7'h00);
        wr(1'b1, 7'h7F);
        chk("R8 flag after writes", rd_data, 8'h80);
        wr(1'b0, 7'b0_0_001_00);
        p3_pins = 4'hF;
        stop_enter = 1'b1; tick(); stop_enter = 1'b0;
        chk("R8 flag during second stop", rd_data, 8'h80);
        p3_pins = 4'h0;
        tick();
        chk("R9 no delay when disabled", delay_active, 0);
        chk("R8 flag after second wake", rd_data, 8'h80);
        do_reset();
        chk("R8 flag cleared by reset", rd_data, 8'h00);

        // R9 reset default has delay enabled
        wr(1'b1, 7'd1);
        p2_pins = 8'h00;
        stop_enter = 1'b1; tick(); stop_enter = 1'b0;
        p2_pins = 8'hF0;
        tick();
        chk("R9 default delay on", {wake_req, delay_active}, 2'b11);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule